// File: doc/BRIEF.md
# Memory Test Address Walker

This block produces the sequence of DRAM addresses that a built-in memory self-test visits. The address is held as three fields: row, column and bank. The width of each field is set at run time, up to a maximum fixed by parameters. A start pulse loads a first address, a final address and the walk settings. After that, each step pulse moves the walk to the next address, until the final address has been presented.

The walk settings are as follows. An order code picks which field changes fastest and how carries ripple between the fields. A direction bit makes the walk count up or down. An alternate-inversion bit shows every second address with all bits inside each field's width flipped. The column is also presented as DRAM address lines, with line A10 held low, because that line carries the auto-precharge flag.

The walker does not pace DRAM commands, issue refresh or map addresses to ranks. A test controller drives `step` at whatever rate its command timing allows.

Top module: `mt_addr_walker`

## Requirements
- R1: One cycle after `start`, `addr_valid` is 1. The outputs then show the start row, column and bank, each masked to its programmed width, and inversion is not applied to this first address.
- R2: Order code 0 (row first): each advance increments the row. The column advances only when the row wraps. The bank advances only when both the row and the column wrap.
- R3: Order code 1 (column first): each advance increments the column. The row advances only when the column wraps. The bank advances only when both the column and the row wrap.
- R4: Order code 2 (row and column together): each advance steps both the row and the column. The bank advances when the row wraps.
- R5: Order code 3 (row, then bank, then column): each advance increments the row. The bank advances when the row wraps. The column advances only when both the row and the bank wrap.
- R6: With `count_down` = 1, every field decrements instead of incrementing. A field at 0 borrows by wrapping to all ones within its width.
- R7: `addr_last` is 1 exactly while the address shown equals the programmed end address. The next `step` after that clears `addr_valid` and `addr_last`. A start address equal to the end address gives `addr_last` = 1 on the first address.
- R8: With `inv_alt` = 1, the addresses at odd positions of the walk (the second, fourth, and so on) are shown bitwise inverted within each field's width. The addresses at even positions are shown unchanged.
- R9: `col_lines` maps column bits [9:0] to lines [9:0] and column bits [12:10] to lines [13:11]. Line 10 is always 0.
- R10: After reset, `addr_valid` and `addr_last` are 0.
- R11: A cycle without `step` holds the address. A `step` while `addr_valid` is 0 has no effect.
- R12: A field's value stays within its programmed width, and the field wraps at 2^width. A width code of 0 acts as 1 bit. A width code above the field's maximum acts as the maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Load settings, start and end addresses; begin a walk |
| step | input | 1 | Advance to the next address |
| order_sel | input | 2 | Field order code (0..3, see R2 to R5) |
| count_down | input | 1 | 1 = decrementing walk |
| inv_alt | input | 1 | 1 = invert every second address |
| row_bits | input | 5 | Row field width code |
| col_bits | input | 4 | Column field width code |
| bank_bits | input | 2 | Bank field width code |
| start_row | input | 16 | First row |
| start_col | input | 13 | First column |
| start_bank | input | 3 | First bank |
| end_row | input | 16 | Final row |
| end_col | input | 13 | Final column |
| end_bank | input | 3 | Final bank |
| row_out | output | 16 | Current row |
| col_out | output | 13 | Current column |
| bank_out | output | 3 | Current bank |
| col_lines | output | 14 | Column on DRAM address lines, line 10 low |
| addr_valid | output | 1 | An address is being presented |
| addr_last | output | 1 | Current address is the end address |

## Verification
The bench runs full walks over a small address space (4 rows, 4 columns, 2 banks) in every order code and both directions. In each walk, every address is compared against an index decomposed into mixed-radix digits. This separates the four orderings, because each one places the carry between the fields at a different point. Partial walks with inversion, started from a nonzero index, show whether inversion follows the walk position or the address value. A walk with a 1-bit row and an over-range column width code shows width clamping and wrap at the top of a 13-bit column, and also exercises the address-line mapping on large column values. A walk whose start equals its end, together with steps issued while idle, covers the termination and ignore rules.

// File: rtl/mt_addr_pkg.sv
// Shared types for the memory test address walker.
// Assumes: order codes are decoded by the walker top and the order controller.
package mt_addr_pkg;

    // Field ordering of the walk; the code values are part of the interface.
    typedef enum logic [1:0] {
        ORD_ROW_FIRST  = 2'd0,
        ORD_COL_FIRST  = 2'd1,
        ORD_DIAGONAL   = 2'd2,
        ORD_ROW_BANK   = 2'd3
    } mt_order_e;

endpackage

// File: rtl/mt_field_step.sv
// One address field: derives its width mask from a width code and computes
// the next value (increment or decrement) with wrap detection.
// Assumes: cur is already inside the mask; W >= 2.
module mt_field_step #(
    parameter int W  = 16,
    parameter int WB = 5
) (
    input  logic [W-1:0]  cur,
    input  logic [WB-1:0] bits,
    input  logic          en,
    input  logic          down,
    output logic [W-1:0]  nxt,
    output logic [W-1:0]  mask,
    output logic          wrap
);
    localparam logic [W-1:0] ONE = W'(1);

    int eff_w;

    // Clamp the width code to 1..W and build the low-ones mask.
    always_comb begin
        if (bits == '0) begin
            eff_w = 1;
        end else if (int'(bits) > W) begin
            eff_w = W;
        end else begin
            eff_w = int'(bits);
        end
        for (int i = 0; i < W; i++) begin
            mask[i] = (i < eff_w);
        end
    end

    // Wrap happens at the top of the range going up, at zero going down.
    always_comb begin
        if (down) begin
            wrap = (cur == '0);
        end else begin
            wrap = (cur == mask);
        end
    end

    // Next value: hold, wrap, or count by one.
    always_comb begin
        if (!en) begin
            nxt = cur;
        end else if (wrap) begin
            nxt = down ? mask : '0;
        end else if (down) begin
            nxt = cur - ONE;
        end else begin
            nxt = cur + ONE;
        end
    end

endmodule

// File: rtl/mt_order_ctrl.sv
// Carry routing between the row, column and bank fields for each order code.
// Assumes: wrap inputs describe the current (not next) field values.
module mt_order_ctrl
    import mt_addr_pkg::*;
(
    input  mt_order_e order,
    input  logic      wrap_row,
    input  logic      wrap_col,
    input  logic      wrap_bank,
    output logic      en_row,
    output logic      en_col,
    output logic      en_bank
);
    // Select which fields move on an advance.
    always_comb begin
        unique case (order)
            ORD_ROW_FIRST: begin
                en_row  = 1'b1;
                en_col  = wrap_row;
                en_bank = wrap_row & wrap_col;
            end
            ORD_COL_FIRST: begin
                en_col  = 1'b1;
                en_row  = wrap_col;
                en_bank = wrap_col & wrap_row;
            end
            ORD_DIAGONAL: begin
                en_row  = 1'b1;
                en_col  = 1'b1;
                en_bank = wrap_row;
            end
            default: begin
                en_row  = 1'b1;
                en_bank = wrap_row;
                en_col  = wrap_row & wrap_bank;
            end
        endcase
    end

endmodule

// File: rtl/mt_addr_fmt.sv
// Output formatting: optional inversion within field widths and the
// column-to-address-line mapping that skips one line.
// Assumes: field values are inside their masks; GAP <= COL_W.
module mt_addr_fmt #(
    parameter int ROW_W  = 16,
    parameter int COL_W  = 13,
    parameter int BANK_W = 3,
    parameter int GAP    = 10
) (
    input  logic [ROW_W-1:0]  row_in,
    input  logic [COL_W-1:0]  col_in,
    input  logic [BANK_W-1:0] bank_in,
    input  logic [ROW_W-1:0]  row_mask,
    input  logic [COL_W-1:0]  col_mask,
    input  logic [BANK_W-1:0] bank_mask,
    input  logic              invert,
    output logic [ROW_W-1:0]  row_o,
    output logic [COL_W-1:0]  col_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [COL_W:0]    lines_o
);
    // Flip only the bits inside each field's width.
    always_comb begin
        row_o  = invert ? (row_in  ^ row_mask)  : row_in;
        col_o  = invert ? (col_in  ^ col_mask)  : col_in;
        bank_o = invert ? (bank_in ^ bank_mask) : bank_in;
    end

    // Spread the column onto address lines, leaving the gap line low.
    for (genvar i = 0; i <= COL_W; i++) begin : g_line
        if (i < GAP) begin : g_low
            assign lines_o[i] = col_o[i];
        end else if (i == GAP) begin : g_gap
            assign lines_o[i] = 1'b0;
        end else begin : g_high
            assign lines_o[i] = col_o[i-1];
        end
    end

endmodule

// File: rtl/mt_addr_walker.sv
// Memory test address walker: holds the current row/column/bank, latches the
// walk settings on start, advances on step in the selected field order and
// direction, flags the end address and stops after it.
// Assumes: the end address is reachable from the start address under the
// chosen order and direction; settings are sampled only on start.
module mt_addr_walker
    import mt_addr_pkg::*;
#(
    parameter int ROW_W  = 16,
    parameter int COL_W  = 13,
    parameter int BANK_W = 3,
    parameter int GAP    = 10
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic                         step,
    input  logic [1:0]                   order_sel,
    input  logic                         count_down,
    input  logic                         inv_alt,
    input  logic [$clog2(ROW_W+1)-1:0]   row_bits,
    input  logic [$clog2(COL_W+1)-1:0]   col_bits,
    input  logic [$clog2(BANK_W+1)-1:0]  bank_bits,
    input  logic [ROW_W-1:0]             start_row,
    input  logic [COL_W-1:0]             start_col,
    input  logic [BANK_W-1:0]            start_bank,
    input  logic [ROW_W-1:0]             end_row,
    input  logic [COL_W-1:0]             end_col,
    input  logic [BANK_W-1:0]            end_bank,
    output logic [ROW_W-1:0]             row_out,
    output logic [COL_W-1:0]             col_out,
    output logic [BANK_W-1:0]            bank_out,
    output logic [COL_W:0]               col_lines,
    output logic                         addr_valid,
    output logic                         addr_last
);
    localparam int RWB = $clog2(ROW_W + 1);
    localparam int CWB = $clog2(COL_W + 1);
    localparam int BWB = $clog2(BANK_W + 1);

    // Latched walk settings.
    mt_order_e         cfg_order;
    logic              cfg_down;
    logic              cfg_inv;
    logic [RWB-1:0]    cfg_rbits;
    logic [CWB-1:0]    cfg_cbits;
    logic [BWB-1:0]    cfg_bbits;
    logic [ROW_W-1:0]  end_row_q;
    logic [COL_W-1:0]  end_col_q;
    logic [BANK_W-1:0] end_bank_q;

    // Walk state.
    logic [ROW_W-1:0]  cur_row;
    logic [COL_W-1:0]  cur_col;
    logic [BANK_W-1:0] cur_bank;
    logic              odd_pos;

    // Next-state and mask wires.
    logic [RWB-1:0]    sel_rbits;
    logic [CWB-1:0]    sel_cbits;
    logic [BWB-1:0]    sel_bbits;
    logic [ROW_W-1:0]  nxt_row, row_mask;
    logic [COL_W-1:0]  nxt_col, col_mask;
    logic [BANK_W-1:0] nxt_bank, bank_mask;
    logic              wrap_row, wrap_col, wrap_bank;
    logic              en_row, en_col, en_bank;
    logic              start_is_end;
    logic              next_is_end;

    // Width codes: new ones while loading, latched ones otherwise.
    always_comb begin
        sel_rbits = start ? row_bits  : cfg_rbits;
        sel_cbits = start ? col_bits  : cfg_cbits;
        sel_bbits = start ? bank_bits : cfg_bbits;
    end

    mt_field_step #(.W(ROW_W), .WB(RWB)) u_row (
        .cur  (cur_row),
        .bits (sel_rbits),
        .en   (en_row),
        .down (cfg_down),
        .nxt  (nxt_row),
        .mask (row_mask),
        .wrap (wrap_row)
    );

    mt_field_step #(.W(COL_W), .WB(CWB)) u_col (
        .cur  (cur_col),
        .bits (sel_cbits),
        .en   (en_col),
        .down (cfg_down),
        .nxt  (nxt_col),
        .mask (col_mask),
        .wrap (wrap_col)
    );

    mt_field_step #(.W(BANK_W), .WB(BWB)) u_bank (
        .cur  (cur_bank),
        .bits (sel_bbits),
        .en   (en_bank),
        .down (cfg_down),
        .nxt  (nxt_bank),
        .mask (bank_mask),
        .wrap (wrap_bank)
    );

    mt_order_ctrl u_order (
        .order     (cfg_order),
        .wrap_row  (wrap_row),
        .wrap_col  (wrap_col),
        .wrap_bank (wrap_bank),
        .en_row    (en_row),
        .en_col    (en_col),
        .en_bank   (en_bank)
    );

    // End detection for a freshly loaded start and for the next address.
    always_comb begin
        start_is_end = (((start_row  ^ end_row)  & row_mask)  == '0) &&
                       (((start_col  ^ end_col)  & col_mask)  == '0) &&
                       (((start_bank ^ end_bank) & bank_mask) == '0);
        next_is_end  = (nxt_row == end_row_q) && (nxt_col == end_col_q) &&
                       (nxt_bank == end_bank_q);
    end

    // Settings register: captured only when a walk starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_order  <= ORD_ROW_FIRST;
            cfg_down   <= 1'b0;
            cfg_inv    <= 1'b0;
            cfg_rbits  <= '0;
            cfg_cbits  <= '0;
            cfg_bbits  <= '0;
            end_row_q  <= '0;
            end_col_q  <= '0;
            end_bank_q <= '0;
        end else if (start) begin
            cfg_order  <= mt_order_e'(order_sel);
            cfg_down   <= count_down;
            cfg_inv    <= inv_alt;
            cfg_rbits  <= row_bits;
            cfg_cbits  <= col_bits;
            cfg_bbits  <= bank_bits;
            end_row_q  <= end_row  & row_mask;
            end_col_q  <= end_col  & col_mask;
            end_bank_q <= end_bank & bank_mask;
        end
    end

    // Walk register: load, advance, or finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_row    <= '0;
            cur_col    <= '0;
            cur_bank   <= '0;
            odd_pos    <= 1'b0;
            addr_valid <= 1'b0;
            addr_last  <= 1'b0;
        end else if (start) begin
            cur_row    <= start_row  & row_mask;
            cur_col    <= start_col  & col_mask;
            cur_bank   <= start_bank & bank_mask;
            odd_pos    <= 1'b0;
            addr_valid <= 1'b1;
            addr_last  <= start_is_end;
        end else if (step && addr_valid) begin
            if (addr_last) begin
                addr_valid <= 1'b0;
                addr_last  <= 1'b0;
            end else begin
                cur_row    <= nxt_row;
                cur_col    <= nxt_col;
                cur_bank   <= nxt_bank;
                odd_pos    <= ~odd_pos;
                addr_last  <= next_is_end;
            end
        end
    end

    mt_addr_fmt #(
        .ROW_W  (ROW_W),
        .COL_W  (COL_W),
        .BANK_W (BANK_W),
        .GAP    (GAP)
    ) u_fmt (
        .row_in    (cur_row),
        .col_in    (cur_col),
        .bank_in   (cur_bank),
        .row_mask  (row_mask),
        .col_mask  (col_mask),
        .bank_mask (bank_mask),
        .invert    (cfg_inv & odd_pos),
        .row_o     (row_out),
        .col_o     (col_out),
        .bank_o    (bank_out),
        .lines_o   (col_lines)
    );

endmodule

// File: rtl/mt_addr_walker_chk.sv
// Protocol checks for the address walker, bound to every instance.
module mt_addr_walker_chk #(
    parameter int ROW_W  = 16,
    parameter int COL_W  = 13,
    parameter int BANK_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              step,
    input logic [ROW_W-1:0]  row_out,
    input logic [COL_W-1:0]  col_out,
    input logic [BANK_W-1:0] bank_out,
    input logic              addr_valid,
    input logic              addr_last
);
    AST_START_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> addr_valid); // R1

    AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        addr_last |-> addr_valid); // R7

    AST_STOP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && addr_last && step && !start) |=> !addr_valid); // R7

    AST_HOLD_WITHOUT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !step && !start) |=>
            ($stable(row_out) && $stable(col_out) && $stable(bank_out))); // R11

    AST_IDLE_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_valid && !start) |=> !addr_valid); // R11

    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |=> (!addr_valid && !addr_last)); // R10

endmodule

bind mt_addr_walker mt_addr_walker_chk #(
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .BANK_W (BANK_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .step       (step),
    .row_out    (row_out),
    .col_out    (col_out),
    .bank_out   (bank_out),
    .addr_valid (addr_valid),
    .addr_last  (addr_last)
);

// File: tb/mt_addr_walker_test.sv
`timescale 1ns/1ps
module mt_addr_walker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, step = 1'b0;
    logic [1:0]  order_sel = '0;
    logic        count_down = 1'b0, inv_alt = 1'b0;
    logic [4:0]  row_bits = '0;
    logic [3:0]  col_bits = '0;
    logic [1:0]  bank_bits = '0;
    logic [15:0] start_row = '0, end_row = '0;
    logic [12:0] start_col = '0, end_col = '0;
    logic [2:0]  start_bank = '0, end_bank = '0;
    logic [15:0] row_out;
    logic [12:0] col_out;
    logic [2:0]  bank_out;
    logic [13:0] col_lines;
    logic        addr_valid, addr_last;

    int n_checks = 0;
    int n_fail = 0;
    bit timed_out = 1'b0;

    always #2 clk = ~clk;

    mt_addr_walker uut (
        .clk(clk), .rst_n(rst_n), .start(start), .step(step),
        .order_sel(order_sel), .count_down(count_down), .inv_alt(inv_alt),
        .row_bits(row_bits), .col_bits(col_bits), .bank_bits(bank_bits),
        .start_row(start_row), .start_col(start_col), .start_bank(start_bank),
        .end_row(end_row), .end_col(end_col), .end_bank(end_bank),
        .row_out(row_out), .col_out(col_out), .bank_out(bank_out),
        .col_lines(col_lines), .addr_valid(addr_valid), .addr_last(addr_last)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Expected fields {bank[2:0], col[12:0], row[15:0]} for walk index n.
    function automatic logic [31:0] decode(int mode, int n, int rx, int ry, int rz);
        int r, c, b;
        case (mode)
            0: begin r = n % rx; c = (n / rx) % ry; b = n / (rx * ry); end
            1: begin c = n % ry; r = (n / ry) % rx; b = n / (rx * ry); end
            2: begin r = n % rx; c = n % rx; b = (n / rx) % rz; end
            default: begin r = n % rx; b = (n / rx) % rz; c = n / (rx * rz); end
        endcase
        return {b[2:0], c[12:0], r[15:0]};
    endfunction

    function automatic logic [33:0] observed();
        return {addr_valid, addr_last, bank_out, col_out, row_out};
    endfunction

    // Run one walk and compare every presented address.
    task automatic walk(input int mode, input bit down, input bit inv,
                        input int rcode, input int ccode, input int bcode,
                        input int rx, input int ry, input int rz,
                        input int sidx, input int eidx, input string req);
        logic [31:0] s, e, flip, exp_f;
        logic [33:0] exp_all, held;
        int len;
        s = decode(mode, sidx, rx, ry, rz);
        e = decode(mode, eidx, rx, ry, rz);
        flip = {3'(rz - 1), 13'(ry - 1), 16'(rx - 1)};
        len = down ? (sidx - eidx + 1) : (eidx - sidx + 1);
        order_sel = 2'(mode); count_down = down; inv_alt = inv;
        row_bits = 5'(rcode); col_bits = 4'(ccode); bank_bits = 2'(bcode);
        {start_bank, start_col, start_row} = s;
        {end_bank, end_col, end_row} = e;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < len; i++) begin
            exp_f = decode(mode, down ? sidx - i : sidx + i, rx, ry, rz);
            if (inv && (i % 2 == 1)) exp_f = exp_f ^ flip;
            exp_all = {1'b1, (i == len - 1), exp_f};
            check(observed() === exp_all, req, $sformatf("address %0d", i),
                  64'(observed()), 64'(exp_all));
            check(col_lines === {exp_f[28:26], 1'b0, exp_f[25:16]}, "R9",
                  "column lines", 64'(col_lines),
                  64'({exp_f[28:26], 1'b0, exp_f[25:16]}));
            if (i == 2 && len > 4) begin
                held = observed();
                step = 1'b0;
                @(negedge clk);
                check(observed() === held, "R11", "hold without step",
                      64'(observed()), 64'(held));
            end
            step = 1'b1;
            @(negedge clk);
        end
        check(addr_valid === 1'b0 && addr_last === 1'b0, "R7", "stop after last",
              64'({addr_valid, addr_last}), 64'(0));
        @(negedge clk);
        check(addr_valid === 1'b0, "R11", "step while idle",
              64'(addr_valid), 64'(0));
        step = 1'b0;
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                check(addr_valid === 1'b0 && addr_last === 1'b0, "R10",
                      "reset state", 64'({addr_valid, addr_last}), 64'(0));
                rst_n = 1'b1;
                step = 1'b1;
                repeat (3) @(negedge clk);
                check(addr_valid === 1'b0, "R11", "step before start",
                      64'(addr_valid), 64'(0));
                step = 1'b0;
                // Full sweeps of a 4x4x2 space in each order and direction.
                walk(0, 0, 0, 2, 2, 1, 4, 4, 2, 0, 31, "R2");
                walk(0, 1, 0, 2, 2, 1, 4, 4, 2, 31, 0, "R6");
                walk(1, 0, 0, 2, 2, 1, 4, 4, 2, 0, 31, "R3");
                walk(1, 1, 0, 2, 2, 1, 4, 4, 2, 31, 0, "R6");
                walk(3, 0, 0, 2, 2, 1, 4, 4, 2, 0, 31, "R5");
                walk(3, 1, 0, 2, 2, 1, 4, 4, 2, 31, 0, "R6");
                walk(2, 0, 0, 2, 2, 1, 4, 4, 2, 0, 7, "R4");
                walk(2, 1, 0, 2, 2, 1, 4, 4, 2, 7, 0, "R4");
                // Partial walks with inversion and nonzero start.
                walk(0, 0, 1, 2, 2, 1, 4, 4, 2, 5, 20, "R8");
                walk(1, 1, 1, 2, 2, 1, 4, 4, 2, 30, 3, "R8");
                // Start equal to end.
                walk(0, 0, 0, 2, 2, 1, 4, 4, 2, 9, 9, "R7");
                // Width clamping: row code 0 -> 1 bit, col code 15 -> 13 bits.
                walk(0, 0, 0, 0, 2, 1, 2, 4, 2, 0, 15, "R12");
                walk(1, 0, 0, 1, 15, 0, 2, 8192, 2, 8190, 8193, "R12");
                walk(1, 0, 1, 1, 15, 0, 2, 8192, 2, 3077, 3080, "R1");
            end
            begin
                #(200000 * 4);
                timed_out = 1'b1;
            end
        join_any
        if (timed_out) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule